// File: doc/BRIEF.md
# Four-Phase Handshake Stage Controller

This block is the control unit of one pipeline stage placed between an upstream and a downstream request/acknowledge channel. Both channels use four-phase, return-to-zero signalling. Every request and acknowledge wire goes back low before the next transfer starts. Between the two channels the controller drives a datapath through a compute phase and a reset phase, using a start output and a done input.

The model is synchronous. Every handshake edge is seen as a level sampled on the rising clock edge, and every output is a registered value.

A transfer has two phases:

- **Set phase.** Upstream request rises, then start rises, then done rises. The result is then captured and the downstream request rises. The downstream acknowledge follows, and finally the upstream acknowledge.
- **Reset phase.** The same signals fall back in the same order.

No step has a time limit. The controller waits at each step for as long as its neighbour takes. A sticky error output reports two protocol violations by the neighbours.

Top module: `rtz_stage_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output (`up_ack_o`, `dp_go_o`, `dn_req_o`, `proto_err_o`, `dn_data_o`) is 0 after that edge, and the controller is idle.
- R2: When idle, `up_req_i` seen high sets `dp_go_o` one edge later. After the transfer is acknowledged upstream, `up_req_i` seen low clears `dp_go_o` one edge later. No other input changes `dp_go_o`.
- R3: While `dp_go_o` is high and before any result has been taken, the first edge that sees `dp_fin_i` high does two things. It loads `dp_data_i` into `dn_data_o`, and it sets `dn_req_o`. No load happens while `dp_fin_i` is low.
- R4: `dn_data_o` keeps the loaded value while `dn_req_o` is high, and it keeps it until the next load, whatever `dp_data_i` does.
- R5: `up_ack_o` rises one edge after `dn_ack_i` is seen high while `dn_req_o` is high. It does not rise before that.
- R6: After `dp_go_o` has fallen, `dn_req_o` falls one edge after `dp_fin_i` is seen low. It does not fall while `dp_fin_i` stays high.
- R7: After `dn_req_o` has fallen, `up_ack_o` falls one edge after `dn_ack_i` is seen low. The controller is then idle and accepts a new request.
- R8: `proto_err_o` rises one edge after `dp_fin_i` is seen falling while `dp_go_o` is high.
- R9: `proto_err_o` rises one edge after `dn_ack_i` is seen rising while `dn_req_o` is low. That edge moves no other output.
- R10: Once set, `proto_err_o` stays high until reset.
- R11: Each step waits without limit. Any number of idle cycles at any step leaves the order of events and the captured data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_req_i | input | 1 | Upstream request |
| up_ack_o | output | 1 | Upstream acknowledge |
| dp_go_o | output | 1 | Start command to the datapath |
| dp_fin_i | input | 1 | Completion from the datapath |
| dp_data_i | input | DATA_W | Datapath result |
| dn_req_o | output | 1 | Downstream request |
| dn_ack_i | input | 1 | Downstream acknowledge |
| dn_data_o | output | DATA_W | Registered result toward downstream |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
Every output is one register away from the inputs. Each result is therefore due exactly one rising edge after the input change that causes it, and never earlier. Loading the data and raising the downstream request happen on that same edge.

The bench changes its inputs on a falling edge and compares the outputs on the next falling edge. It holds an input for several extra cycles only where it also needs to show that an output has not moved too early. The checks of the reset phase follow the same one-edge rule, step by step.

// File: rtl/rtz_pkg.sv
package rtz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GO,
        ST_SENT,
        ST_ACKD,
        ST_DROP,
        ST_RTZ
    } rtz_state_e;

    typedef struct packed {
        rtz_state_e st;
        logic       go;
        logic       req;
        logic       ack;
    } rtz_seq_t;

    typedef struct packed {
        logic fin_prev;
        logic ack_prev;
        logic err;
    } rtz_viol_t;

    localparam rtz_seq_t SEQ_RESET = '{st: ST_IDLE, go: 1'b0, req: 1'b0, ack: 1'b0};

endpackage

// File: rtl/rtz_seq.sv
module rtz_seq
    import rtz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic dp_fin,
    input  logic dn_ack,
    output logic dp_go,
    output logic dn_req,
    output logic up_ack,
    output logic load
);

    rtz_seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        unique case (s_q.st)
            ST_IDLE: if (up_req) begin
                s_d.st = ST_GO;
                s_d.go = 1'b1;
            end
            ST_GO: if (dp_fin) begin
                s_d.st  = ST_SENT;
                s_d.req = 1'b1;
                load    = 1'b1;
            end
            ST_SENT: if (dn_ack) begin
                s_d.st  = ST_ACKD;
                s_d.ack = 1'b1;
            end
            ST_ACKD: if (!up_req) begin
                s_d.st = ST_DROP;
                s_d.go = 1'b0;
            end
            ST_DROP: if (!dp_fin) begin
                s_d.st  = ST_RTZ;
                s_d.req = 1'b0;
            end
            ST_RTZ: if (!dn_ack) begin
                s_d.st  = ST_IDLE;
                s_d.ack = 1'b0;
            end
            default: s_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= SEQ_RESET;
        else        s_q <= s_d;
    end

    assign dp_go  = s_q.go;
    assign dn_req = s_q.req;
    assign up_ack = s_q.ack;

endmodule

// File: rtl/rtz_capture.sv
module rtz_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) hold_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign dout = hold_q;

endmodule

// File: rtl/rtz_violation.sv
module rtz_violation
    import rtz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dp_go,
    input  logic dp_fin,
    input  logic dn_req,
    input  logic dn_ack,
    output logic err
);

    rtz_viol_t v_d, v_q;
    logic      fin_drop_bad;
    logic      ack_rise_bad;

    always_comb begin
        fin_drop_bad = v_q.fin_prev && !dp_fin && dp_go;
        ack_rise_bad = !v_q.ack_prev && dn_ack && !dn_req;
        v_d.fin_prev = dp_fin;
        v_d.ack_prev = dn_ack;
        v_d.err      = v_q.err || fin_drop_bad || ack_rise_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign err = v_q.err;

endmodule

// File: rtl/rtz_stage_ctrl.sv
module rtz_stage_ctrl #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req_i,
    output logic              up_ack_o,
    output logic              dp_go_o,
    input  logic              dp_fin_i,
    input  logic [DATA_W-1:0] dp_data_i,
    output logic              dn_req_o,
    input  logic              dn_ack_i,
    output logic [DATA_W-1:0] dn_data_o,
    output logic              proto_err_o
);

    logic load;

    rtz_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .up_req (up_req_i),
        .dp_fin (dp_fin_i),
        .dn_ack (dn_ack_i),
        .dp_go  (dp_go_o),
        .dn_req (dn_req_o),
        .up_ack (up_ack_o),
        .load   (load)
    );

    rtz_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (dp_data_i),
        .dout  (dn_data_o)
    );

    rtz_violation u_viol (
        .clk    (clk),
        .rst_n  (rst_n),
        .dp_go  (dp_go_o),
        .dp_fin (dp_fin_i),
        .dn_req (dn_req_o),
        .dn_ack (dn_ack_i),
        .err    (proto_err_o)
    );

endmodule

// File: rtl/rtz_stage_ctrl_chk.sv
module rtz_stage_ctrl_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_req_i,
    input logic              up_ack_o,
    input logic              dp_go_o,
    input logic              dp_fin_i,
    input logic              dn_req_o,
    input logic              dn_ack_i,
    input logic [DATA_W-1:0] dn_data_o,
    input logic              proto_err_o
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!up_ack_o && !dp_go_o && !dn_req_o && !proto_err_o && dn_data_o == '0));

    p_go_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dp_go_o) |-> (!$past(up_req_i) && up_ack_o));

    p_req_after_fin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req_o) |-> ($past(dp_fin_i) && dp_go_o));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_o && $past(dn_req_o)) |-> $stable(dn_data_o));

    p_ack_after_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ack_o) |-> ($past(dn_ack_i) && $past(dn_req_o)));

    p_req_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn_req_o) |-> (!dp_go_o && !$past(dp_fin_i)));

    p_ack_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_ack_o) |-> (!$past(dn_ack_i) && !dn_req_o));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);

endmodule

bind rtz_stage_ctrl rtz_stage_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_req_i    (up_req_i),
    .up_ack_o    (up_ack_o),
    .dp_go_o     (dp_go_o),
    .dp_fin_i    (dp_fin_i),
    .dn_req_o    (dn_req_o),
    .dn_ack_i    (dn_ack_i),
    .dn_data_o   (dn_data_o),
    .proto_err_o (proto_err_o)
);

// File: tb/test_rtz_stage_ctrl.sv
`timescale 1ns/1ps
module test_rtz_stage_ctrl;

    localparam int unsigned DW = 8;
    localparam int NVEC = 8;

    // {req,fin,ack, data[7:0], exp ack,go,req,err, exp dout[7:0]}
    localparam logic [22:0] VEC [NVEC] = '{
        {3'b100, 8'h00, 4'b0100, 8'h00},  // R2 go rises
        {3'b100, 8'h3C, 4'b0100, 8'h00},  // R3 no load without fin
        {3'b110, 8'hA5, 4'b0110, 8'hA5},  // R3 load + req
        {3'b110, 8'h5A, 4'b0110, 8'hA5},  // R4 hold, R5 no early ack
        {3'b111, 8'h5A, 4'b1110, 8'hA5},  // R5 ack up
        {3'b011, 8'h5A, 4'b1010, 8'hA5},  // R2 go falls
        {3'b001, 8'h5A, 4'b1000, 8'hA5},  // R6 req falls
        {3'b000, 8'h5A, 4'b0000, 8'hA5}   // R7 ack falls
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req = 1'b0, dp_fin = 1'b0, dn_ack = 1'b0;
    logic [DW-1:0] dp_data = '0;
    logic          up_ack, dp_go, dn_req, perr;
    logic [DW-1:0] dn_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rtz_stage_ctrl #(.DATA_W(DW)) i_rtz_stage_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_req_i    (up_req),
        .up_ack_o    (up_ack),
        .dp_go_o     (dp_go),
        .dp_fin_i    (dp_fin),
        .dp_data_i   (dp_data),
        .dn_req_o    (dn_req),
        .dn_ack_i    (dn_ack),
        .dn_data_o   (dn_data),
        .proto_err_o (perr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] outs();
        return {up_ack, dp_go, dn_req, perr, dn_data};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        up_req = 1'b0; dp_fin = 1'b0; dn_ack = 1'b0;
        rst_n = 1'b0;
        step(); step();
        check("R1 reset state", 32'(outs()), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        for (int i = 0; i < NVEC; i++) begin
            {up_req, dp_fin, dn_ack} = VEC[i][22:20];
            dp_data = VEC[i][19:12];
            step();
            check($sformatf("R2-R7 table vector %0d", i), 32'(outs()), 32'(VEC[i][11:0]));
        end

        // R11: random waits at every step
        for (int t = 0; t < 8; t++) begin
            logic [DW-1:0] val;
            val = DW'($urandom);
            up_req = 1'b1;
            step();
            check("R2 go after req", 32'({dp_go, dn_req}), 32'b10);
            repeat ($urandom_range(4, 0)) step();
            check("R11 waiting for fin", 32'({dp_go, dn_req, up_ack}), 32'b100);
            dp_fin = 1'b1; dp_data = val;
            step();
            check("R3 load with req", 32'({dn_req, dn_data}), 32'({1'b1, val}));
            dp_data = ~val;
            repeat ($urandom_range(4, 0)) step();
            check("R4 data held", 32'({up_ack, dn_data}), 32'({1'b0, val}));
            dn_ack = 1'b1;
            step();
            check("R5 ack up", 32'(up_ack), 32'h1);
            repeat ($urandom_range(4, 0)) step();
            check("R11 waiting for req low", 32'(dp_go), 32'h1);
            up_req = 1'b0;
            step();
            check("R2 go down", 32'({dp_go, dn_req}), 32'b01);
            repeat ($urandom_range(4, 0)) step();
            check("R6 req held while fin high", 32'(dn_req), 32'h1);
            dp_fin = 1'b0;
            step();
            check("R6 req down", 32'({dn_req, up_ack}), 32'b01);
            repeat ($urandom_range(4, 0)) step();
            dn_ack = 1'b0;
            step();
            check("R7 ack down", 32'({up_ack, perr, dn_data}), 32'({2'b00, val}));
        end

        // R8 and R10: fin drops while go is high
        up_req = 1'b1;
        step();
        dp_fin = 1'b1; dp_data = 8'hC3;
        step();
        check("R8 no error yet", 32'(perr), 32'h0);
        dp_fin = 1'b0;
        step();
        check("R8 fin drop flagged", 32'(perr), 32'h1);
        repeat (5) step();
        check("R10 error sticky", 32'(perr), 32'h1);
        do_reset();

        // R9: ack rises while req is low
        dn_ack = 1'b1;
        step();
        check("R9 stray ack flagged", 32'(outs()), 32'h100);
        dn_ack = 1'b0;
        step();
        check("R9 controller untouched", 32'({up_ack, dp_go, dn_req}), 32'h0);
        check("R10 error stays", 32'(perr), 32'h1);
        do_reset();
        check("R1 error cleared", 32'(perr), 32'h0);

        finish_run();
    end

endmodule